// File: doc/BRIEF.md
# Serial Flash Continuous Array Read Engine

This block is the slave-side control for one read command of a serial flash device. It streams the memory array out through a serial link. It watches an active-low chip select, a serial clock and a serial data input, all oversampled on the system clock. It shifts in an 8-bit command code and then a 24-bit address that names a page and a starting byte. A run of don't-care clocks follows. After that run the block drives array bytes on a serial output, one bit for each falling serial clock edge, with the most significant bit first, for as long as chip select stays low.

The array sits behind a synchronous read port with a latency of one cycle. The engine keeps its own page/byte counter. While the current byte is being shifted out, it fetches the byte that follows. The stream therefore moves from the end of one page to the start of the next, and from the end of the last page back to page 0, with no idle serial clocks between bytes. Raising chip select ends the transfer at any point and disables the output driver. Any command code other than continuous read is ignored until the next deselect.

Top module: `fcr_read_engine`

## Requirements
- R1: While chip select is high, and after reset, `so_oe` is low and no memory read is issued.
- R2: The first 8 bits after chip select falls are taken on rising serial clock edges, most significant bit first. The value 0xE8 starts a read. Any other value keeps `so_oe` low and issues no memory read until chip select rises.
- R3: The next 24 bits are the address, most significant bit first. Bits 22..10 are the page and bits 9..0 are the starting byte. Bit 23 is ignored, and so are the page bits above the log2(PAGES) lowest. The byte sent is the one at linear port address page*PAGE_BYTES+byte.
- R4: A starting byte of PAGE_BYTES or more begins the stream at byte 0 of the addressed page.
- R5: After the address, exactly DUMMY_CLKS rising edges (32 by default) pass with `so_oe` low. The first data bit is driven on the first falling edge after them.
- R6: In the data phase, each falling serial clock edge drives one data bit, most significant bit first, with `so_oe` high. `so` changes only after a falling edge.
- R7: Within a page, byte n is followed directly by byte n+1.
- R8: After byte PAGE_BYTES-1 of a page, the stream continues at byte 0 of the next page with no idle clocks.
- R9: After the last byte of page PAGES-1, the stream continues at byte 0 of page 0 with no idle clocks.
- R10: A rising chip select ends the operation at any point. `so_oe` is low within SYNC_STAGES+1 system clock cycles, and the next command is decoded from scratch.
- R11: Both serial clock idle levels work: low (mode 0) and high (mode 3).
- R12: Memory reads are single-cycle pulses, one for each streamed byte, always at an address below PAGES*PAGE_BYTES.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the serial pins |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Active-low chip select |
| sck | input | 1 | Serial clock from the host |
| si | input | 1 | Serial data from the host |
| so | output | 1 | Serial data to the host, valid while `so_oe` is high |
| so_oe | output | 1 | Output driver enable; low means high impedance |
| mem_rd_en | output | 1 | Array read strobe |
| mem_addr | output | MEM_AW | Linear array byte address |
| mem_rd_data | input | 8 | Array byte, valid one cycle after the strobe |

## Verification
The assertions watch every cycle for several properties. The output enable must drop, and reads must stop, a fixed number of cycles after deselect. Nothing may be driven during the dummy phase or after an unknown opcode. The output bit may move only on a sampled falling edge. Every read must be a single in-range pulse. The directed scenarios are the only place to see the stream contents. They show that the page and byte fields decode correctly, that the start-byte clamp works, that the dummy count is exact to the bit, that no gap or skip appears at page crossovers and at the wrap to page 0, that a new command starts cleanly after an aborted read, and that both clock idle levels behave the same.

// File: rtl/fcr_pkg.sv
package fcr_pkg;
   localparam logic [7:0] OP_CONT_READ = 8'hE8;
   localparam int         ADDR_BITS    = 24;
   localparam int         PG_LSB       = 10;

   typedef enum logic [2:0] {
      ST_CMD,
      ST_ADDR,
      ST_DUMMY,
      ST_DATA,
      ST_IGNORE
   } fcr_state_e;
endpackage

// File: rtl/fcr_sampler.sv
module fcr_sampler #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic cs_n_in,
   input  logic sck_in,
   input  logic si_in,
   output logic cs_n_o,
   output logic si_o,
   output logic sck_rise,
   output logic sck_fall
);
   logic [STAGES-1:0] cs_p, sck_p, si_p;
   logic              sck_last;

   generate
      if (STAGES == 1) begin : g_single
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               cs_p  <= '1;
               sck_p <= '0;
               si_p  <= '0;
            end else begin
               cs_p  <= cs_n_in;
               sck_p <= sck_in;
               si_p  <= si_in;
            end
         end
      end else begin : g_chain
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               cs_p  <= '1;
               sck_p <= '0;
               si_p  <= '0;
            end else begin
               cs_p  <= {cs_p[STAGES-2:0], cs_n_in};
               sck_p <= {sck_p[STAGES-2:0], sck_in};
               si_p  <= {si_p[STAGES-2:0], si_in};
            end
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sck_last <= 1'b0;
      else        sck_last <= sck_p[STAGES-1];
   end

   assign cs_n_o   = cs_p[STAGES-1];
   assign si_o     = si_p[STAGES-1];
   assign sck_rise =  sck_p[STAGES-1] & ~sck_last;
   assign sck_fall = ~sck_p[STAGES-1] &  sck_last;
endmodule

// File: rtl/fcr_addr_ctr.sv
module fcr_addr_ctr #(
   parameter int PAGE_BYTES = 16,
   parameter int PAGES      = 8,
   parameter int BYTE_W     = 4,
   parameter int PAGE_W     = 3,
   parameter int MEM_AW     = 7
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [PAGE_W-1:0] load_page,
   input  logic [9:0]        load_byte,
   input  logic              step,
   output logic [MEM_AW-1:0] mem_addr
);
   logic [PAGE_W-1:0] pg_q;
   logic [BYTE_W-1:0] by_q;
   logic              byte_in_range;

   assign byte_in_range = int'(load_byte) < PAGE_BYTES;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pg_q <= '0;
         by_q <= '0;
      end else if (load) begin
         pg_q <= load_page;
         by_q <= byte_in_range ? load_byte[BYTE_W-1:0] : '0;
      end else if (step) begin
         if (by_q == BYTE_W'(PAGE_BYTES - 1)) begin
            by_q <= '0;
            pg_q <= (pg_q == PAGE_W'(PAGES - 1)) ? '0 : pg_q + PAGE_W'(1);
         end else begin
            by_q <= by_q + BYTE_W'(1);
         end
      end
   end

   assign mem_addr = MEM_AW'(pg_q) * MEM_AW'(PAGE_BYTES) + MEM_AW'(by_q);
endmodule

// File: rtl/fcr_read_engine.sv
module fcr_read_engine
   import fcr_pkg::*;
#(
   parameter int PAGE_BYTES  = 16,
   parameter int PAGES       = 8,
   parameter int DUMMY_CLKS  = 32,
   parameter int SYNC_STAGES = 2,
   localparam int DEPTH      = PAGES * PAGE_BYTES,
   localparam int MEM_AW     = $clog2(DEPTH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cs_n,
   input  logic              sck,
   input  logic              si,
   output logic              so,
   output logic              so_oe,
   output logic              mem_rd_en,
   output logic [MEM_AW-1:0] mem_addr,
   input  logic [7:0]        mem_rd_data
);
   localparam int BYTE_W = $clog2(PAGE_BYTES);
   localparam int PAGE_W = $clog2(PAGES);
   localparam int SH_W   = PG_LSB + PAGE_W;
   localparam int CNT_MX = (DUMMY_CLKS > ADDR_BITS) ? DUMMY_CLKS : ADDR_BITS;
   localparam int CNT_W  = $clog2(CNT_MX + 1);

   initial begin
      assert (PAGE_BYTES >= 2 && PAGE_BYTES <= 1024)
         else $error("PAGE_BYTES must lie in 2..1024");
      assert (PAGES >= 2 && PAGES <= 8192)
         else $error("PAGES must lie in 2..8192");
      assert (DUMMY_CLKS >= 1) else $error("DUMMY_CLKS must be at least 1");
      assert (SYNC_STAGES >= 1) else $error("SYNC_STAGES must be at least 1");
   end

   logic cs_s, si_s, sck_rise, sck_fall;

   fcr_sampler #(.STAGES(SYNC_STAGES)) u_smp (
      .clk      (clk),
      .rst_n    (rst_n),
      .cs_n_in  (cs_n),
      .sck_in   (sck),
      .si_in    (si),
      .cs_n_o   (cs_s),
      .si_o     (si_s),
      .sck_rise (sck_rise),
      .sck_fall (sck_fall)
   );

   fcr_state_e       state_q;
   logic [CNT_W-1:0] cnt_q;
   logic [SH_W-2:0]  sh_q;
   logic [SH_W-1:0]  in_bits;
   logic [6:0]       out_q;
   logic [2:0]       bit_q;
   logic [7:0]       nxt_q;
   logic             so_q, oe_q, rd_req_q, rd_ack_q;
   logic             ld, stp;

   assign in_bits = {sh_q, si_s};

   always_comb begin
      ld  = 1'b0;
      stp = 1'b0;
      if (!cs_s) begin
         if (state_q == ST_ADDR && sck_rise && cnt_q == CNT_W'(ADDR_BITS - 1))
            ld = 1'b1;
         if (state_q == ST_DATA && sck_fall && bit_q == 3'd0)
            stp = 1'b1;
      end
   end

   fcr_addr_ctr #(
      .PAGE_BYTES (PAGE_BYTES),
      .PAGES      (PAGES),
      .BYTE_W     (BYTE_W),
      .PAGE_W     (PAGE_W),
      .MEM_AW     (MEM_AW)
   ) u_ctr (
      .clk       (clk),
      .rst_n     (rst_n),
      .load      (ld),
      .load_page (in_bits[PG_LSB +: PAGE_W]),
      .load_byte (in_bits[9:0]),
      .step      (stp),
      .mem_addr  (mem_addr)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_req_q <= 1'b0;
         rd_ack_q <= 1'b0;
         nxt_q    <= '0;
      end else begin
         rd_req_q <= ld | stp;
         rd_ack_q <= rd_req_q;
         if (rd_ack_q) nxt_q <= mem_rd_data;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_CMD;
         cnt_q   <= '0;
         sh_q    <= '0;
         out_q   <= '0;
         bit_q   <= '0;
         so_q    <= 1'b0;
         oe_q    <= 1'b0;
      end else if (cs_s) begin
         state_q <= ST_CMD;
         cnt_q   <= '0;
         bit_q   <= '0;
         oe_q    <= 1'b0;
      end else begin
         unique case (state_q)
            ST_CMD: if (sck_rise) begin
               sh_q <= in_bits[SH_W-2:0];
               if (cnt_q == CNT_W'(7)) begin
                  cnt_q   <= '0;
                  state_q <= (in_bits[7:0] == OP_CONT_READ) ? ST_ADDR : ST_IGNORE;
               end else begin
                  cnt_q <= cnt_q + CNT_W'(1);
               end
            end
            ST_ADDR: if (sck_rise) begin
               sh_q <= in_bits[SH_W-2:0];
               if (cnt_q == CNT_W'(ADDR_BITS - 1)) begin
                  cnt_q   <= '0;
                  state_q <= ST_DUMMY;
               end else begin
                  cnt_q <= cnt_q + CNT_W'(1);
               end
            end
            ST_DUMMY: if (sck_rise) begin
               if (cnt_q == CNT_W'(DUMMY_CLKS - 1)) begin
                  cnt_q   <= '0;
                  bit_q   <= '0;
                  state_q <= ST_DATA;
               end else begin
                  cnt_q <= cnt_q + CNT_W'(1);
               end
            end
            ST_DATA: if (sck_fall) begin
               oe_q  <= 1'b1;
               bit_q <= bit_q + 3'd1;
               if (bit_q == 3'd0) begin
                  so_q  <= nxt_q[7];
                  out_q <= nxt_q[6:0];
               end else begin
                  so_q  <= out_q[6];
                  out_q <= {out_q[5:0], 1'b0};
               end
            end
            default: ;
         endcase
      end
   end

   assign so        = so_q;
   assign so_oe     = oe_q;
   assign mem_rd_en = rd_req_q;
endmodule

// File: rtl/fcr_read_engine_chk.sv
module fcr_read_engine_chk
   import fcr_pkg::*;
#(
   parameter int DEPTH       = 128,
   parameter int SYNC_STAGES = 2,
   parameter int MEM_AW      = 7
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cs_n,
   input logic              so,
   input logic              so_oe,
   input logic              mem_rd_en,
   input logic [MEM_AW-1:0] mem_addr,
   input logic              sck_fall,
   input fcr_state_e        state_q
);
   localparam int HI_MAX = SYNC_STAGES + 3;
   int hi_cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      hi_cnt <= 0;
      else if (!cs_n)  hi_cnt <= 0;
      else if (hi_cnt < HI_MAX) hi_cnt <= hi_cnt + 1;
   end

   a_r10_deselect_hiz: assert property (@(posedge clk) disable iff (!rst_n)
      (hi_cnt > SYNC_STAGES) |-> !so_oe);

   a_r1_idle_no_read: assert property (@(posedge clk) disable iff (!rst_n)
      (hi_cnt > SYNC_STAGES + 1) |-> !mem_rd_en);

   a_r2_ignore_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_IGNORE) |-> (!so_oe && !mem_rd_en));

   a_r5_dummy_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_DUMMY) |-> !so_oe);

   a_r6_so_moves_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
      (so_oe && $past(so_oe) && !$past(sck_fall)) |-> $stable(so));

   a_r12_addr_range: assert property (@(posedge clk) disable iff (!rst_n)
      mem_rd_en |-> (int'(mem_addr) < DEPTH));

   a_r12_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      mem_rd_en |=> !mem_rd_en);
endmodule

bind fcr_read_engine fcr_read_engine_chk #(
   .DEPTH       (DEPTH),
   .SYNC_STAGES (SYNC_STAGES),
   .MEM_AW      (MEM_AW)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .cs_n      (cs_n),
   .so        (so),
   .so_oe     (so_oe),
   .mem_rd_en (mem_rd_en),
   .mem_addr  (mem_addr),
   .sck_fall  (sck_fall),
   .state_q   (state_q)
);

// File: tb/sim_fcr_read_engine.sv
module sim_fcr_read_engine;
   localparam int PB     = 12;
   localparam int NP     = 4;
   localparam int DEPTH  = PB * NP;
   localparam int AW     = $clog2(DEPTH);
   localparam int DUMMY  = 32;
   localparam int HALF   = 6;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          cs_n = 1'b1;
   logic          sck = 1'b0;
   logic          si = 1'b0;
   logic          so, so_oe, mem_rd_en;
   logic [AW-1:0] mem_addr;
   logic [7:0]    mem_rd_data = 8'h00;

   int checks = 0;
   int errors = 0;
   int rd_count = 0;
   int cycles = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   fcr_read_engine #(
      .PAGE_BYTES  (PB),
      .PAGES       (NP),
      .DUMMY_CLKS  (DUMMY),
      .SYNC_STAGES (2)
   ) u0 (
      .clk         (clk),
      .rst_n       (rst_n),
      .cs_n        (cs_n),
      .sck         (sck),
      .si          (si),
      .so          (so),
      .so_oe       (so_oe),
      .mem_rd_en   (mem_rd_en),
      .mem_addr    (mem_addr),
      .mem_rd_data (mem_rd_data)
   );

   function automatic logic [7:0] pat(int a);
      return 8'(a * 37 + 11);
   endfunction

   always_ff @(posedge clk) begin
      if (mem_rd_en) begin
         mem_rd_data <= pat(int'(mem_addr));
         rd_count    <= rd_count + 1;
      end
   end

   always @(posedge clk) begin
      cycles <= cycles + 1;
      if (cycles > 150000 && !done) begin
         done = 1'b1;
         errors = errors + 1;
         checks = checks + 1;
         $display("FAIL watchdog: run did not finish, actual=%0d expected<150000", cycles);
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual=0x%0h expected=0x%0h", req, what, act, exp);
      end
   endtask

   task automatic clk_bit(input logic b, output logic s_so, output logic s_oe);
      @(negedge clk);
      sck = 1'b0;
      si  = b;
      repeat (HALF) @(negedge clk);
      s_so = so;
      s_oe = so_oe;
      sck  = 1'b1;
      repeat (HALF - 1) @(negedge clk);
   endtask

   task automatic send_byte(input logic [7:0] v);
      logic a, b;
      for (int i = 7; i >= 0; i--) clk_bit(v[i], a, b);
   endtask

   task automatic begin_cmd(input bit mode3);
      @(negedge clk);
      sck  = mode3;
      cs_n = 1'b1;
      repeat (4) @(negedge clk);
      cs_n = 1'b0;
      repeat (4) @(negedge clk);
   endtask

   task automatic end_cmd(input bit mode3);
      @(negedge clk);
      cs_n = 1'b1;
      repeat (2) @(negedge clk);
      sck = mode3;
      repeat (6) @(negedge clk);
   endtask

   task automatic read_stream(input logic [23:0] addr, input bit mode3, input int nbytes,
                              input int start_lin, input string req);
      logic a, b;
      int   dummy_bad;
      begin_cmd(mode3);
      send_byte(8'hE8);
      send_byte(addr[23:16]);
      send_byte(addr[15:8]);
      send_byte(addr[7:0]);
      dummy_bad = 0;
      for (int i = 0; i < DUMMY; i++) begin
         clk_bit(1'b1, a, b);
         if (b) dummy_bad++;
      end
      chk(dummy_bad == 0, "R5", "so_oe high during dummy clocks", dummy_bad, 0);
      for (int k = 0; k < nbytes; k++) begin
         logic [7:0] got;
         int         oe_low;
         int         exp_lin;
         oe_low  = 0;
         exp_lin = (start_lin + k) % DEPTH;
         for (int i = 7; i >= 0; i--) begin
            clk_bit(1'b0, a, b);
            got[i] = a;
            if (!b) oe_low++;
         end
         chk(oe_low == 0, "R6", "so_oe low in data phase", oe_low, 0);
         chk(got == pat(exp_lin), req, $sformatf("byte %0d of stream", k),
             int'(got), int'(pat(exp_lin)));
      end
      end_cmd(mode3);
   endtask

   task automatic t_reset();
      repeat (3) @(negedge clk);
      chk(so_oe == 1'b0, "R1", "so_oe after reset", int'(so_oe), 0);
      chk(rd_count == 0, "R1", "reads while deselected", rd_count, 0);
   endtask

   task automatic t_basic();
      // page 1, byte 3 -> linear 15; R3 decode, R7 sequential bytes
      read_stream({1'b0, 13'd1, 10'd3}, 1'b0, 5, 15, "R3/R7");
   endtask

   task automatic t_page_roll();
      // page 0, byte 10: crosses to page 1 after byte 11 (R8)
      read_stream({1'b0, 13'd0, 10'd10}, 1'b0, 8, 10, "R8");
   endtask

   task automatic t_wrap();
      // page 3, byte 10: wraps to page 0 byte 0 (R9)
      read_stream({1'b0, 13'd3, 10'd10}, 1'b0, 5, 46, "R9");
   endtask

   task automatic t_reserved_bits();
      // bit 23 and page bit 12 set; both ignored -> page 2 byte 5 (R3)
      read_stream({1'b1, 13'h1002, 10'd5}, 1'b0, 2, 29, "R3");
   endtask

   task automatic t_start_clamp();
      // byte 14 is past the 12-byte page: start at byte 0 of page 1 (R4)
      read_stream({1'b0, 13'd1, 10'd14}, 1'b0, 2, 12, "R4");
   endtask

   task automatic t_mode3();
      // clock idles high (R11)
      read_stream({1'b0, 13'd2, 10'd7}, 1'b1, 3, 31, "R11");
   endtask

   task automatic t_bad_opcode();
      logic a, b;
      int   oe_hi;
      int   rd0;
      rd0   = rd_count;
      oe_hi = 0;
      begin_cmd(1'b0);
      send_byte(8'h0B);
      for (int i = 0; i < 80; i++) begin
         clk_bit(i[0], a, b);
         if (b) oe_hi++;
      end
      chk(oe_hi == 0, "R2", "so_oe after unknown opcode", oe_hi, 0);
      chk(rd_count == rd0, "R2", "reads after unknown opcode", rd_count - rd0, 0);
      end_cmd(1'b0);
      read_stream({1'b0, 13'd0, 10'd0}, 1'b0, 2, 0, "R2");
   endtask

   task automatic t_abort();
      logic a, b;
      begin_cmd(1'b0);
      send_byte(8'hE8);
      send_byte(8'h00);
      send_byte(8'h04);
      send_byte(8'h02);
      for (int i = 0; i < DUMMY; i++) clk_bit(1'b0, a, b);
      for (int i = 0; i < 11; i++) clk_bit(1'b0, a, b);
      chk(so_oe == 1'b1, "R10", "so_oe before deselect", int'(so_oe), 1);
      @(negedge clk);
      cs_n = 1'b1;
      repeat (4) @(negedge clk);
      chk(so_oe == 1'b0, "R10", "so_oe after mid-byte deselect", int'(so_oe), 0);
      repeat (4) @(negedge clk);
      read_stream({1'b0, 13'd1, 10'd0}, 1'b0, 2, 12, "R10");
   endtask

   initial begin
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_basic();
      t_page_roll();
      t_wrap();
      t_reserved_bits();
      t_start_clamp();
      t_mode3();
      t_bad_opcode();
      t_abort();
      if (!done) begin
         done = 1'b1;
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule